// File: doc/BRIEF.md
# Frame and Multiframe Sync Generator

This block divides the main equipment output clock into two square-wave timing references: a frame-rate signal and a multiframe-rate signal. The multiframe signal runs at one quarter of the frame rate. Both outputs have an equal high and low time. The multiframe rising edge always lands on a frame rising edge, so downstream logic can use the two signals as a nested timing hierarchy.

Timing units can be deployed in redundant pairs. In that case, one unit is the master and runs its dividers freely. The other unit is the slave. It watches the master's multiframe output on a dedicated input, passes that signal through a synchronizer, and restarts both of its dividers on each rising edge it sees. After the restart, both of the slave's outputs begin a fresh high phase, so the two units stay in phase. The role is a plain input. It is registered every cycle, including during reset, so it can be changed at any time.

With a 19.44 MHz clock, the default divisor gives an 8 kHz frame output with a 2430-cycle period and a 2 kHz multiframe output.

Top module: `fsync_gen`

## Requirements
- R1: `frame_sync` is a square wave that holds each level for exactly HALF_CYC clock cycles, giving a period of 2*HALF_CYC cycles and a 50:50 duty cycle, except where an R6 restart cuts a phase short.
- R2: `multi_sync` holds each level for exactly MF_RATIO*HALF_CYC cycles, so its period is MF_RATIO frame periods. Its high phase starts together with a frame high phase.
- R3: While `rst` is high at a clock edge, both outputs are driven high and the dividers sit at the start of a high phase. The first cycle after reset is therefore cycle 0 of a frame high phase and of a multiframe high phase.
- R4: In free running operation, every MF_RATIO-th rising edge of `frame_sync` occurs in the same cycle as a rising edge of `multi_sync`.
- R5: When `role_sel` is 0 (master), `partner_mf` has no effect on either output.
- R6: When `role_sel` is 1 (slave), a 0-to-1 change of `partner_mf` takes effect on a particular clock edge. Call the first edge that samples `partner_mf` high edge 0. Both dividers are reloaded on edge 2. From edge 2 onward, `frame_sync` and `multi_sync` are high and restart their R1/R2 timing from cycle 0.
- R7: In slave mode, a restart happens only on a 0-to-1 change of `partner_mf`. Holding `partner_mf` high, or driving it from 1 to 0, does not disturb the free running timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main equipment output clock |
| rst | input | 1 | Synchronous active-high reset |
| role_sel | input | 1 | Redundancy role: 0 master, 1 slave |
| partner_mf | input | 1 | Multiframe sync from the partner unit (asynchronous) |
| frame_sync | output | 1 | Frame-rate square wave |
| multi_sync | output | 1 | Multiframe-rate square wave |

## Verification
Some properties are checked by assertions on every cycle:
- the half-period counter stays within range;
- the frame level holds between counter wraps;
- the multiframe output only rises while the frame output is high;
- the synchronizer never emits two edge pulses back to back;
- a slave restart leaves both outputs high with the counter at zero.

Other properties can only be shown by the bench's scenarios:
- the exact period and duty of both outputs over long stretches;
- that a master ignores random partner activity;
- the exact two-edge restart latency;
- that a partner signal held high causes no repeated restarts.

// File: rtl/fsync_pkg.sv
package fsync_pkg;

    typedef enum logic {
        ROLE_MASTER = 1'b0,
        ROLE_SLAVE  = 1'b1
    } role_e;

    typedef struct packed {
        logic frame;
        logic multi;
    } sync_pair_t;

    // Half-period index -> output levels. Even half-periods are frame-high;
    // the first 'ratio' half-periods of a multiframe are multiframe-high.
    function automatic sync_pair_t phase_to_sync(input int unsigned idx,
                                                 input int unsigned ratio);
        sync_pair_t s;
        s.frame = (idx % 2) == 0;
        s.multi = idx < ratio;
        return s;
    endfunction

endpackage

// File: rtl/fsync_edge_sync.sv
module fsync_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    // chain[0..STAGES-1] is the synchronizer, chain[STAGES] holds the prior value
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= async_i;
    end

    for (genvar g = 1; g <= STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[g] <= 1'b0;
            else     chain[g] <= chain[g-1];
        end
    end

    assign rise_o = chain[STAGES-1] & ~chain[STAGES];

    // R7: one pulse per rising edge, never two in a row
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/fsync_divider.sv
module fsync_divider
    import fsync_pkg::*;
#(
    parameter int HALF_CYC = 1215,
    parameter int MF_RATIO = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reload_i,
    output sync_pair_t sync_o
);
    localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam int IDX_N = 2 * MF_RATIO;
    localparam int IDX_W = (IDX_N > 1) ? $clog2(IDX_N) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic             wrap;

    assign wrap = (cnt_q == CNT_W'(HALF_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || reload_i) begin
            cnt_q <= '0;
            idx_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
            idx_q <= (idx_q == IDX_W'(IDX_N - 1)) ? '0 : idx_q + IDX_W'(1);
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign sync_o = phase_to_sync(32'(idx_q), MF_RATIO);

    p_cnt_range_r1: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(HALF_CYC));

    p_frame_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!wrap && !reload_i) |=> $stable(sync_o.frame));

    p_multi_on_frame_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_o.multi) |-> sync_o.frame);

    p_reload_start_r6: assert property (@(posedge clk) disable iff (rst)
        reload_i |=> (sync_o.frame && sync_o.multi && cnt_q == '0));

endmodule

// File: rtl/fsync_gen.sv
module fsync_gen
    import fsync_pkg::*;
#(
    parameter int HALF_CYC    = 1215,
    parameter int MF_RATIO    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic role_sel,
    input  logic partner_mf,
    output logic frame_sync,
    output logic multi_sync
);
    role_e      role_q;
    logic       partner_rise;
    logic       reload;
    sync_pair_t sync_w;

    // role register, loaded during reset and tracking the pin afterwards
    always_ff @(posedge clk) begin
        role_q <= role_e'(role_sel);
    end

    fsync_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (partner_mf),
        .rise_o  (partner_rise)
    );

    assign reload = partner_rise && (role_q == ROLE_SLAVE);

    fsync_divider #(.HALF_CYC(HALF_CYC), .MF_RATIO(MF_RATIO)) u_div (
        .clk      (clk),
        .rst      (rst),
        .reload_i (reload),
        .sync_o   (sync_w)
    );

    assign frame_sync = sync_w.frame;
    assign multi_sync = sync_w.multi;

    p_slave_realign_r6: assert property (@(posedge clk) disable iff (rst)
        (role_q == ROLE_SLAVE && partner_rise) |=> (frame_sync && multi_sync));

endmodule

// File: tb/fsync_gen_tb.sv
module fsync_gen_tb;
    localparam int HALF  = 6;
    localparam int RATIO = 4;
    localparam int MP    = 2 * RATIO * HALF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic role_sel = 1'b0;
    logic partner = 1'b0;
    logic fs, mfs;

    int total = 0;
    int bad = 0;
    string tag = "";

    // bench model state
    int n = 0;
    int rise_age = -1;
    bit p_last = 1'b0;
    bit role_m = 1'b0;
    bit fs_prev = 1'b1;
    bit mfs_prev = 1'b1;

    fsync_gen #(.HALF_CYC(HALF), .MF_RATIO(RATIO), .SYNC_STAGES(2)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .role_sel   (role_sel),
        .partner_mf (partner),
        .frame_sync (fs),
        .multi_sync (mfs)
    );

    always #5 clk = ~clk;

    // expected timing from the requirements: cycles since the last start
    always @(posedge clk) begin
        if (rst) begin
            n = 0;
            rise_age = -1;
            p_last = 1'b0;
            role_m = role_sel;
        end else begin
            bit rl;
            rl = (rise_age == 1) && role_m;
            n = rl ? 0 : n + 1;
            if (rise_age >= 0) rise_age = (rise_age >= 2) ? -1 : rise_age + 1;
            if (partner && !p_last) rise_age = 0;
            p_last = partner;
            role_m = role_sel;
        end
    end

    function automatic bit exp_frame(int c);
        return ((c / HALF) % 2) == 0;
    endfunction

    function automatic bit exp_multi(int c);
        return ((c / HALF) % (2 * RATIO)) < RATIO;
    endfunction

    task automatic chk(string req, logic got, logic exp, string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s at n=%0d: actual=%b expected=%b", req, what, n, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        chk((tag == "") ? "R1" : tag, fs, exp_frame(n), "frame_sync");
        chk((tag == "") ? "R2" : tag, mfs, exp_multi(n), "multi_sync");
        if (n > 0 && (n % MP) == 0) begin
            // R4: multiframe rise coincides with a frame rise
            chk("R4", (!fs_prev && fs && !mfs_prev && mfs), 1'b1, "coincident rise");
        end
        fs_prev = fs;
        mfs_prev = mfs;
    endtask

    task automatic steps(int k);
        for (int i = 0; i < k; i++) step();
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd7919));
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R3: reset state
        chk("R3", fs, 1'b1, "frame_sync in reset");
        chk("R3", mfs, 1'b1, "multi_sync in reset");
        rst = 1'b0;
        tag = "R3";
        step();
        tag = "";
        steps(3 * MP);

        // R5: master ignores random partner activity
        tag = "R5";
        for (int i = 0; i < 4 * MP; i++) begin
            partner = ($urandom_range(0, 3) == 0) ? ~partner : partner;
            step();
        end
        partner = 1'b0;
        steps(5);

        // slave, partner quiet: free running
        role_sel = 1'b1;
        tag = "";
        steps(MP + 7);

        // R6: directed restart, then explicit phase checks
        tag = "R6";
        partner = 1'b1;
        step();
        step();
        step();
        chk("R6", fs, 1'b1, "frame high after restart");
        chk("R6", mfs, 1'b1, "multi high after restart");
        steps(HALF - 1);
        chk("R6", fs, 1'b1, "frame still high at end of phase");
        step();
        chk("R6", fs, 1'b0, "frame low after one half period");

        // R7: partner held high, then released, no further restarts
        tag = "R7";
        steps(3 * MP);
        partner = 1'b0;
        steps(2 * MP);

        // R6: random partner pulses in slave mode
        tag = "R6";
        for (int j = 0; j < 25; j++) begin
            int gap;
            int width;
            gap = $urandom_range(3, 2 * MP);
            width = $urandom_range(1, 3 * HALF);
            steps(gap);
            partner = 1'b1;
            steps(width);
            partner = 1'b0;
        end
        steps(MP);

        // R5: back to master with random partner activity
        role_sel = 1'b0;
        steps(3);
        tag = "R5";
        for (int i = 0; i < 4 * MP; i++) begin
            partner = ($urandom_range(0, 2) == 0) ? ~partner : partner;
            step();
        end
        partner = 1'b0;
        steps(MP);

        summary();
        $finish;
    end
endmodule